// File: doc/BRIEF.md
# DMA Burst-Read Request Handshake

This block is the device side of an external DMA read port that empties an internal first-word-fall-through FIFO toward a host. When at least one burst worth of words is waiting, it raises a request line. The host answers with an acknowledge and then strobes a read line once per word. Each strobe pops one word from the FIFO, and the head word is presented on the host data bus. A burst always moves a fixed number of words, 16 by default.

A small configuration field sets how the request behaves. A nonzero value gives a request pulse that lasts that many core clocks. Zero gives a level request, which is held until the first read strobe is seen. A fly-by select replaces the normal read strobe with a dedicated fly-by strobe. Both host inputs, the acknowledge and the selected strobe, pass through a synchronizer before any edge is detected.

Two kinds of host misbehaviour are flagged, and each flag holds until reset. A strobe phase that is too short, or a strobe that arrives without an acknowledge, raises the protocol flag. An acknowledge that drops in the middle of a burst aborts the burst and raises the abort flag.

Top module: `dma_burst_rd`

## Requirements
- R1: From idle, a request is raised only if `fifo_level` was at least BURST_LEN (16) in the cycle before the request goes high. While the level stays below that, no request appears.
- R2: When `cfg_req_len` is N, with N from 1 to 15, the request is high for exactly N consecutive clock cycles per burst. It drops earlier only if the first word is popped first.
- R3: When `cfg_req_len` is 0, the request stays high until the first acknowledged strobe. It then falls on the third clock edge after the strobe rises at the pin: two synchronizer stages, then one request register.
- R4: Each synchronized rising edge of the selected strobe that comes with a synchronized acknowledge, during a request or burst, pulses `fifo_pop` for one cycle and advances `word_idx`. After the 16th word, `word_idx` returns to 0.
- R5: `host_data_oe` is high exactly when the synchronized acknowledge and the synchronized selected strobe are both high during a request, burst or tail phase. While it is high, `host_data` equals `fifo_data`; otherwise `host_data` is all zeros.
- R6: After the last strobe of a burst falls at the pin, the next request rises on edge SYNC_STAGES+GAP_CYC+2 (the 6th edge with defaults). This leaves at least GAP_CYC (2) idle cycles after the synchronized strobe falls.
- R7: If the synchronized acknowledge is low while a burst is between word 1 and word 15, the burst is aborted. `word_idx` returns to 0 and `abort_err` is set and stays set until reset.
- R8: Within a burst, a synchronized strobe high phase or low phase shorter than MIN_PHASE (2) cycles sets `proto_err`, which stays set until reset.
- R9: A synchronized strobe rise with the acknowledge low, during a request or burst, sets `proto_err` and pops nothing. A level request stays high in that case.
- R10: With `cfg_flyby` at 1, only `host_flyby_rd` is observed as the strobe; `host_rd` has no effect on pops, index or request. With `cfg_flyby` at 0, the opposite holds.
- R11: After reset, `host_req`, `fifo_pop`, `host_data_oe`, `abort_err` and `proto_err` are 0, `word_idx` is 0 and `host_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_req_len | input | MODE_W | 0 selects a level request; N selects a pulse of N cycles |
| cfg_flyby | input | 1 | 1 selects the fly-by strobe |
| fifo_level | input | LVL_W | Words currently held in the FIFO |
| fifo_data | input | DATA_W | FIFO head word |
| fifo_pop | output | 1 | One-cycle pop of the FIFO head |
| host_req | output | 1 | DMA request to the host |
| host_ack | input | 1 | DMA acknowledge from the host, asynchronous |
| host_rd | input | 1 | Normal read strobe, active high, asynchronous |
| host_flyby_rd | input | 1 | Fly-by read strobe, active high, asynchronous |
| host_data | output | DATA_W | Host data bus, zeros when not enabled |
| host_data_oe | output | 1 | Host data bus drive enable |
| word_idx | output | $clog2(BURST_LEN) | Index of the next word in the burst |
| abort_err | output | 1 | Sticky flag for a burst aborted by the acknowledge |
| proto_err | output | 1 | Sticky flag for a strobe protocol violation |

## Verification
The bench measures request length at the pulse limits of 1 and 15 cycles. A design that mis-loads its counter would stretch or clip these pulses by a cycle. It counts the clock edges from the final strobe release to the next request, which exposes a gap that is too short or a missing synchronizer stage. The corner cases driven include:
- an acknowledge dropped after word 5, where the index must clear and the abort flag must stick;
- one-cycle strobe high phases and one-cycle strobe low phases, which must raise the protocol flag;
- a strobe with no acknowledge, which must not pop;
- toggling the unselected strobe in fly-by mode, which a wrong select would turn into pops.

A cycle-accurate reference model is compared against every output on every clock.

// File: rtl/dma_rd_pkg.sv
package dma_rd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_REQ   = 3'd1,
      ST_BURST = 3'd2,
      ST_TAIL  = 3'd3,
      ST_GAP   = 3'd4
   } rd_state_e;
endpackage

// File: rtl/dma_sync.sv
module dma_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_in};
   end

   assign q_out = chain[STAGES-1];
endmodule

// File: rtl/dma_stb_edge.sv
module dma_stb_edge #(
   parameter int MIN_PHASE = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic rise_o,
   output logic fall_o,
   output logic short_o
);
   localparam int PH_W = $clog2(MIN_PHASE + 1);

   logic            prev_q;
   logic [PH_W-1:0] ph_cnt;
   logic            any_edge;

   assign rise_o   = level_i & ~prev_q;
   assign fall_o   = ~level_i & prev_q;
   assign any_edge = rise_o | fall_o;
   // previous level lasted fewer cycles than the minimum
   assign short_o  = ph_cnt < PH_W'(MIN_PHASE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         ph_cnt <= PH_W'(MIN_PHASE);
      end else begin
         prev_q <= level_i;
         if (any_edge)                        ph_cnt <= PH_W'(1);
         else if (ph_cnt < PH_W'(MIN_PHASE))  ph_cnt <= ph_cnt + PH_W'(1);
      end
   end
endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
   import dma_rd_pkg::*;
#(
   parameter int MODE_W    = 4,
   parameter int BURST_LEN = 16,
   parameter int GAP_CYC   = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         fifo_ok,
   input  logic [MODE_W-1:0]            mode,
   input  logic                         stb_rise,
   input  logic                         stb_fall,
   input  logic                         phase_short,
   input  logic                         ack_q,
   output logic                         req,
   output logic                         busy,
   output logic                         pop,
   output logic [$clog2(BURST_LEN)-1:0] word,
   output logic                         abort_err,
   output logic                         proto_err
);
   localparam int CNT_W = $clog2(BURST_LEN);
   localparam int GAP_W = $clog2(GAP_CYC + 1);
   localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(BURST_LEN - 1);

   rd_state_e          state;
   logic [MODE_W-1:0]  pulse_cnt;
   logic               level_mode;
   logic [GAP_W-1:0]   gap_cnt;

   assign busy = (state == ST_REQ) | (state == ST_BURST) | (state == ST_TAIL);
   assign pop  = stb_rise & ack_q & ((state == ST_REQ) | (state == ST_BURST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         req        <= 1'b0;
         pulse_cnt  <= '0;
         level_mode <= 1'b0;
         gap_cnt    <= '0;
         word       <= '0;
         abort_err  <= 1'b0;
         proto_err  <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (fifo_ok) begin
                  state      <= ST_REQ;
                  req        <= 1'b1;
                  pulse_cnt  <= mode;
                  level_mode <= (mode == '0);
               end
            end
            ST_REQ: begin
               if (!level_mode && req) begin
                  if (pulse_cnt == MODE_W'(1)) req <= 1'b0;
                  else                         pulse_cnt <= pulse_cnt - MODE_W'(1);
               end
               if (stb_rise && !ack_q) proto_err <= 1'b1;
               if (pop) begin
                  req   <= 1'b0;
                  word  <= CNT_W'(1);
                  state <= ST_BURST;
               end
            end
            ST_BURST: begin
               if (stb_rise && (!ack_q || phase_short)) proto_err <= 1'b1;
               if (stb_fall && phase_short)             proto_err <= 1'b1;
               if (!ack_q) begin
                  word      <= '0;
                  abort_err <= 1'b1;
                  gap_cnt   <= GAP_W'(GAP_CYC);
                  state     <= ST_GAP;
               end else if (pop) begin
                  if (word == LAST_WORD) begin
                     word  <= '0;
                     state <= ST_TAIL;
                  end else begin
                     word <= word + CNT_W'(1);
                  end
               end
            end
            ST_TAIL: begin
               if (stb_fall) begin
                  if (phase_short) proto_err <= 1'b1;
                  gap_cnt <= GAP_W'(GAP_CYC);
                  state   <= ST_GAP;
               end
            end
            ST_GAP: begin
               if (gap_cnt == GAP_W'(1)) state   <= ST_IDLE;
               else                      gap_cnt <= gap_cnt - GAP_W'(1);
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dma_burst_rd.sv
module dma_burst_rd #(
   parameter int DATA_W      = 16,
   parameter int LVL_W       = 8,
   parameter int BURST_LEN   = 16,
   parameter int MODE_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int MIN_PHASE   = 2,
   parameter int GAP_CYC     = 2,
   parameter bit FLYBY_EN    = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [MODE_W-1:0]            cfg_req_len,
   input  logic                         cfg_flyby,
   input  logic [LVL_W-1:0]             fifo_level,
   input  logic [DATA_W-1:0]            fifo_data,
   output logic                         fifo_pop,
   output logic                         host_req,
   input  logic                         host_ack,
   input  logic                         host_rd,
   input  logic                         host_flyby_rd,
   output logic [DATA_W-1:0]            host_data,
   output logic                         host_data_oe,
   output logic [$clog2(BURST_LEN)-1:0] word_idx,
   output logic                         abort_err,
   output logic                         proto_err
);
   localparam int LVL_NEED = BURST_LEN;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dma_burst_rd: SYNC_STAGES must be at least 2");
   end
   if (BURST_LEN < 2 || (1 << $clog2(BURST_LEN)) != BURST_LEN) begin : g_bad_len
      $error("dma_burst_rd: BURST_LEN must be a power of two of at least 2");
   end
   if (LVL_NEED >= (1 << LVL_W)) begin : g_bad_lvl
      $error("dma_burst_rd: LVL_W too narrow for BURST_LEN");
   end
   if (MIN_PHASE < 1 || GAP_CYC < 1) begin : g_bad_time
      $error("dma_burst_rd: MIN_PHASE and GAP_CYC must be positive");
   end

   logic stb_raw;
   if (FLYBY_EN) begin : g_flyby
      assign stb_raw = cfg_flyby ? host_flyby_rd : host_rd;
   end else begin : g_plain
      assign stb_raw = host_rd;
   end

   logic stb_q, ack_q;
   dma_sync #(.STAGES(SYNC_STAGES)) u_stb_sync (
      .clk(clk), .rst_n(rst_n), .d_in(stb_raw), .q_out(stb_q));
   dma_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(clk), .rst_n(rst_n), .d_in(host_ack), .q_out(ack_q));

   logic stb_rise, stb_fall, phase_short;
   dma_stb_edge #(.MIN_PHASE(MIN_PHASE)) u_edge (
      .clk(clk), .rst_n(rst_n), .level_i(stb_q),
      .rise_o(stb_rise), .fall_o(stb_fall), .short_o(phase_short));

   logic busy;
   dma_req_ctrl #(.MODE_W(MODE_W), .BURST_LEN(BURST_LEN), .GAP_CYC(GAP_CYC)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .fifo_ok(fifo_level >= LVL_W'(LVL_NEED)),
      .mode(cfg_req_len),
      .stb_rise(stb_rise), .stb_fall(stb_fall), .phase_short(phase_short),
      .ack_q(ack_q),
      .req(host_req), .busy(busy), .pop(fifo_pop), .word(word_idx),
      .abort_err(abort_err), .proto_err(proto_err));

   assign host_data_oe = ack_q & stb_q & busy;
   assign host_data    = host_data_oe ? fifo_data : '0;
endmodule

// File: rtl/dma_burst_rd_chk.sv
module dma_burst_rd_chk #(
   parameter int DATA_W    = 16,
   parameter int LVL_W     = 8,
   parameter int BURST_LEN = 16
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [LVL_W-1:0]             fifo_level,
   input logic                         fifo_pop,
   input logic                         host_req,
   input logic [DATA_W-1:0]            host_data,
   input logic                         host_data_oe,
   input logic [$clog2(BURST_LEN)-1:0] word_idx,
   input logic                         abort_err,
   input logic                         proto_err
);
   // R1
   req_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_req) |-> $past(fifo_level) >= LVL_W'(BURST_LEN));
   // R4
   no_double_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |=> !fifo_pop);
   // R5
   pop_on_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> host_data_oe);
   // R5
   quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !host_data_oe |-> host_data == '0);
   // R7
   abort_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_err |=> abort_err);
   // R7
   abort_clears_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(abort_err) |-> word_idx == '0);
   // R8
   proto_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err);
endmodule

bind dma_burst_rd dma_burst_rd_chk #(
   .DATA_W(DATA_W), .LVL_W(LVL_W), .BURST_LEN(BURST_LEN)
) u_chk (.*);

// File: tb/dma_burst_rd_test.sv
`timescale 1ns/1ps
module dma_burst_rd_test;
   localparam int DW = 16;
   localparam int BL = 16;
   localparam int MINPH = 2;
   localparam int GAP = 2;
   localparam logic [DW-1:0] BASE = 16'hA000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0] cfg_req_len = 4'd0;
   logic cfg_flyby = 1'b0;
   logic [7:0] fifo_level = 8'd0;
   logic [DW-1:0] fifo_data;
   logic fifo_pop, host_req, host_data_oe, abort_err, proto_err;
   logic host_ack = 1'b0, host_rd = 1'b0, host_flyby_rd = 1'b0;
   logic [DW-1:0] host_data;
   logic [3:0] word_idx;

   always #2 clk = ~clk;

   dma_burst_rd uut (
      .clk(clk), .rst_n(rst_n), .cfg_req_len(cfg_req_len), .cfg_flyby(cfg_flyby),
      .fifo_level(fifo_level), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
      .host_req(host_req), .host_ack(host_ack), .host_rd(host_rd),
      .host_flyby_rd(host_flyby_rd), .host_data(host_data),
      .host_data_oe(host_data_oe), .word_idx(word_idx),
      .abort_err(abort_err), .proto_err(proto_err));

   // FIFO head in the bench, advanced by the design's pops
   always @(posedge clk or negedge rst_n)
      if (!rst_n) fifo_data <= BASE;
      else if (fifo_pop) fifo_data <= fifo_data + 16'd1;

   int checks = 0, fails = 0, req_hi = 0;

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
      end
   endtask

   // reference model: 0 idle, 1 request, 2 burst, 3 tail, 4 gap
   int m_st, m_pc, m_word, m_gap, m_ph, m_pops;
   bit m_req, m_lvl, m_abort, m_proto;
   bit s_stb[$], s_ack[$];
   bit hp;

   function automatic bit e_rise(); return s_stb[1] && !hp; endfunction
   function automatic bit e_fall(); return !s_stb[1] && hp; endfunction
   function automatic bit e_oe();
      return s_ack[1] && s_stb[1] && (m_st >= 1 && m_st <= 3);
   endfunction
   function automatic bit e_pop();
      return e_rise() && s_ack[1] && (m_st == 1 || m_st == 2);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_pc = 0; m_word = 0; m_gap = 0; m_ph = MINPH; m_pops = 0;
         m_req = 0; m_lvl = 0; m_abort = 0; m_proto = 0;
         s_stb = '{0, 0}; s_ack = '{0, 0}; hp = 0;
      end else begin
         bit rs, fl, pp, a, sh, raw;
         rs = e_rise(); fl = e_fall(); pp = e_pop(); a = s_ack[1]; sh = (m_ph < MINPH);
         case (m_st)
            0: if (fifo_level >= BL) begin
                  m_st = 1; m_req = 1; m_pc = cfg_req_len; m_lvl = (cfg_req_len == 0);
               end
            1: begin
                  if (!m_lvl && m_req) begin
                     if (m_pc == 1) m_req = 0; else m_pc--;
                  end
                  if (rs && !a) m_proto = 1;
                  if (pp) begin m_req = 0; m_word = 1; m_st = 2; end
               end
            2: begin
                  if (rs && (!a || sh)) m_proto = 1;
                  if (fl && sh) m_proto = 1;
                  if (!a) begin m_word = 0; m_abort = 1; m_gap = GAP; m_st = 4; end
                  else if (pp) begin
                     if (m_word == BL - 1) begin m_word = 0; m_st = 3; end
                     else m_word++;
                  end
               end
            3: if (fl) begin
                  if (sh) m_proto = 1;
                  m_gap = GAP; m_st = 4;
               end
            default: if (m_gap == 1) m_st = 0; else m_gap--;
         endcase
         if (pp) m_pops++;
         if (rs || fl) m_ph = 1; else if (m_ph < MINPH) m_ph++;
         raw = cfg_flyby ? host_flyby_rd : host_rd;
         hp = s_stb[1];
         s_stb = '{raw, s_stb[0]};
         s_ack = '{host_ack, s_ack[0]};
      end
   end

   // per-cycle comparison, away from both edges
   initial forever begin
      @(posedge clk); #1;
      if (rst_n) begin
         string rt;
         logic [DW-1:0] ed;
         rt = (m_st == 0) ? "R1" : (m_st == 4) ? "R6" : (m_st == 1 && m_lvl) ? "R3" : "R2";
         ed = e_oe() ? BASE + DW'(m_pops) : '0;
         check(host_req == m_req, rt, "host_req", host_req, m_req);
         check(fifo_pop == e_pop(), "R4", "fifo_pop", fifo_pop, e_pop());
         check(word_idx == 4'(m_word), "R4", "word_idx", word_idx, m_word);
         check(host_data_oe == e_oe(), "R5", "host_data_oe", host_data_oe, e_oe());
         check(host_data == ed, "R5", "host_data", host_data, ed);
         check(abort_err == m_abort, "R7", "abort_err", abort_err, m_abort);
         check(proto_err == m_proto, "R8", "proto_err", proto_err, m_proto);
         if (host_req) req_hi++;
      end
   end

   task automatic tick(input int n); repeat (n) @(negedge clk); endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; host_ack = 0; host_rd = 0; host_flyby_rd = 0;
      tick(3); rst_n = 1; req_hi = 0;
   endtask

   task automatic set_stb(input bit fb, input bit v);
      if (fb) begin host_flyby_rd = v; host_rd = !v; end
      else host_rd = v;
   endtask

   task automatic wait_req();
      for (int i = 0; i < 200 && m_st != 1; i++) tick(1);
   endtask

   task automatic burst(input int n, input int hi, input int lo, input bit fb, input int drop_at);
      wait_req(); host_ack = 1; tick(2);
      for (int i = 0; i < n; i++) begin
         set_stb(fb, 1); tick(hi); set_stb(fb, 0);
         if (i + 1 == drop_at) host_ack = 0;
         if (i != n - 1) tick(lo);
      end
   endtask

   task automatic run_all();
      int n;
      // R11 reset state
      rst_n = 0; tick(3); rst_n = 1; #1;
      check(host_req == 0 && fifo_pop == 0 && host_data_oe == 0, "R11", "req|pop|oe", host_req, 0);
      check(word_idx == 0 && host_data == 0, "R11", "idx|data", word_idx, 0);
      check(abort_err == 0 && proto_err == 0, "R11", "flags", abort_err, 0);

      // R1 low fill level: no request
      fifo_level = 8'd15; cfg_req_len = 4'd3; tick(30);
      check(req_hi == 0, "R1", "request cycles below fill", req_hi, 0);

      // R2 pulse limits
      do_reset(); cfg_req_len = 4'd1; fifo_level = 8'd40; tick(30);
      check(req_hi == 1, "R2", "pulse length 1", req_hi, 1);
      do_reset(); cfg_req_len = 4'd15; tick(40);
      check(req_hi == 15, "R2", "pulse length 15", req_hi, 15);

      // R4 R6 full pulse-mode burst
      do_reset(); cfg_req_len = 4'd4;
      burst(BL, 3, 3, 0, 0);
      check(req_hi == 4, "R2", "pulse length 4", req_hi, 4);
      n = 0;
      do begin @(posedge clk); #1; n++; end while (!host_req && n < 50);
      check(n == 2 + GAP + 2, "R6", "edges to next request", n, 2 + GAP + 2);
      check(fifo_data == BASE + 16'(BL), "R4", "words popped", fifo_data - BASE, BL);
      check(proto_err == 0 && abort_err == 0, "R4", "clean burst flags", proto_err, 0);

      // R3 level request release
      do_reset(); cfg_req_len = 4'd0; wait_req(); host_ack = 1; tick(10);
      check(host_req == 1, "R3", "level request held", host_req, 1);
      set_stb(0, 1); n = 0;
      do begin @(posedge clk); #1; n++; end while (host_req && n < 20);
      check(n == 3, "R3", "edges to request release", n, 3);
      tick(2); set_stb(0, 0); tick(4);

      // R10 fly-by: normal strobe ignored, fly-by strobe moves data
      do_reset(); cfg_flyby = 1; wait_req(); host_ack = 1;
      for (int i = 0; i < 3; i++) begin host_rd = 1; tick(3); host_rd = 0; tick(3); end
      check(fifo_data == BASE && host_req == 1, "R10", "pops from ignored strobe",
            fifo_data - BASE, 0);
      burst(BL, 3, 3, 1, 0); tick(10);
      check(fifo_data == BASE + 16'(BL), "R10", "fly-by words", fifo_data - BASE, BL);
      cfg_flyby = 0; host_rd = 0;

      // R7 abort after five words
      do_reset(); cfg_req_len = 4'd2;
      burst(5, 3, 3, 0, 5); tick(10);
      check(abort_err == 1, "R7", "abort flag", abort_err, 1);
      check(fifo_data == BASE + 16'd5, "R7", "words before abort", fifo_data - BASE, 5);

      // R8 short high phase, then short low phase
      do_reset(); burst(BL, 1, 3, 0, 0); tick(10);
      check(proto_err == 1, "R8", "short high phase", proto_err, 1);
      do_reset(); burst(BL, 3, 1, 0, 0); tick(10);
      check(proto_err == 1, "R8", "short low phase", proto_err, 1);

      // R9 strobe without acknowledge
      do_reset(); cfg_req_len = 4'd0; wait_req(); tick(2);
      set_stb(0, 1); tick(3); set_stb(0, 0); tick(5);
      check(proto_err == 1, "R9", "strobe without ack flag", proto_err, 1);
      check(fifo_data == BASE && host_req == 1, "R9", "no pop, request held",
            fifo_data - BASE, 0);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            fails++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule